// File: doc/BRIEF.md
# Warp Memory Request Coalescer

This block takes one memory instruction from a 32-lane warp and turns it into the smallest set of aligned bus transactions that covers every active lane's 4-byte word. Each lane gives a 32-bit byte address. An active-lane mask says which lanes take part. A per-instruction mode bit picks the transaction granularity. Cached loads are fetched as whole 128-byte lines. Uncached loads are fetched as 32-byte segments. The same lane addresses can therefore give a different transaction set, and a different number of bytes on the bus, depending on the mode.

The instruction is taken through a valid/ready handshake. The block then walks the distinct units touched by the active lanes, lowest address first. It offers one transaction at a time on a second valid/ready pair, with the unit's base address and its size in bytes. After the last transaction is taken, a one-cycle completion pulse carries the number of transactions and the total bytes moved. Cache lookup, the memory model and the return of data to the lanes sit in other blocks.

Top module: `warp_coalescer`

## Requirements
- R1: When `req_uncached` is 0, every transaction has `txn_size` = 128 and a base address whose low 7 bits are zero.
- R2: When `req_uncached` is 1, every transaction has `txn_size` = 32 and a base address whose low 5 bits are zero.
- R3: The block issues exactly one transaction for each distinct unit touched by the active lanes, and none for any other unit. Both cases below fall under this rule: 32 aligned consecutive words, in any lane order, give 1 line or 4 segments; a misaligned run of 32 words gives 2 lines or 5 segments; and lanes that all name one word give a single transaction.
- R4: Lanes whose mask bit is 0 have no effect on the transaction set. An instruction with an all-zero mask completes with a count of 0 and 0 bytes.
- R5: Within one instruction, the transactions come out in strictly ascending base-address order.
- R6: While `txn_valid` is high and `txn_ready` is low, `txn_valid`, `txn_base` and `txn_size` stay unchanged on the next cycle.
- R7: `done_pulse` is high for exactly one cycle per instruction. While it is high, `done_count` is the number of transactions issued and `done_bytes` equals `done_count` times the unit size.
- R8: `req_ready` is low from the cycle after an instruction is accepted up to and including the cycle of its `done_pulse`. A request held valid during that time is not taken.
- R9: The lowest 2 address bits of each lane have no effect on which unit the lane belongs to.
- R10: `txn_valid` is high in the cycle after acceptance when at least one lane is active. `done_pulse` is high in the cycle after the last transaction handshake. With an empty mask, `done_pulse` is high in the second cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A warp instruction is offered |
| req_ready | output | 1 | The block can take an instruction (idle) |
| req_addr | input | 1024 | Lane byte addresses, lane i at bits [32*i+31 : 32*i] |
| req_mask | input | 32 | Active-lane mask, bit i = lane i |
| req_uncached | input | 1 | 1 = 32-byte segments, 0 = 128-byte lines |
| txn_valid | output | 1 | A bus transaction is offered |
| txn_ready | input | 1 | The bus takes the offered transaction |
| txn_base | output | 32 | Aligned base address of the transaction |
| txn_size | output | 8 | Transaction size in bytes (32 or 128) |
| done_pulse | output | 1 | One-cycle completion strobe |
| done_count | output | 6 | Transactions issued for the instruction |
| done_bytes | output | 13 | Bytes moved for the instruction |

## Verification
An instruction is taken at the clock edge where `req_valid` and `req_ready` are both high. The first transaction is then visible one cycle later. Every later transaction appears in the cycle after the previous handshake, or stays in place while ready is held low. The completion pulse follows the final handshake by one cycle, or comes two cycles after acceptance when no lane is active. The bench drives inputs and samples outputs on the falling edge. It records each handshake in the half-cycle before the edge that completes it, and it checks the pulse, the counts and the return of `req_ready` at exactly those offsets. The recorded list is compared against a sorted unit list that a bench function builds from the lane addresses.

// File: rtl/coal_pkg.sv
package coal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } coal_state_e;

endpackage

// File: rtl/coal_min_tree.sv
module coal_min_tree #(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32
) (
    input  logic [LANES-1:0]        vld,
    input  logic [LANES*ADDR_W-1:0] base,
    output logic                    any,
    output logic [ADDR_W-1:0]       min_base
);
    localparam int NODES = 2 * LANES;

    logic              nv [NODES];
    logic [ADDR_W-1:0] nb [NODES];

    assign nv[0] = 1'b0;
    assign nb[0] = '0;

    for (genvar i = 0; i < LANES; i++) begin : g_leaf
        assign nv[LANES+i] = vld[i];
        assign nb[LANES+i] = base[i*ADDR_W +: ADDR_W];
    end

    for (genvar n = 1; n < LANES; n++) begin : g_node
        logic take_left;
        assign take_left = nv[2*n] && (!nv[2*n+1] || (nb[2*n] <= nb[2*n+1]));
        assign nv[n] = nv[2*n] | nv[2*n+1];
        assign nb[n] = take_left ? nb[2*n] : nb[2*n+1];
    end

    assign any      = nv[1];
    assign min_base = nb[1];

endmodule

// File: rtl/coal_lane_bank.sv
module coal_lane_bank #(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [LANES*ADDR_W-1:0] lane_addr,
    input  logic [LANES-1:0]        lane_mask,
    input  logic [ADDR_W-1:0]       keep_mask,
    input  logic                    clear_en,
    input  logic [ADDR_W-1:0]       clear_base,
    output logic [LANES-1:0]        pend,
    output logic [LANES*ADDR_W-1:0] base,
    output logic                    rest_any
);
    logic [LANES-1:0]        pend_d, pend_q;
    logic [LANES*ADDR_W-1:0] base_d, base_q;
    logic [LANES-1:0]        hit;

    for (genvar i = 0; i < LANES; i++) begin : g_hit
        assign hit[i] = pend_q[i] && (base_q[i*ADDR_W +: ADDR_W] == clear_base);
    end

    always_comb begin
        pend_d = pend_q;
        base_d = base_q;
        if (load) begin
            pend_d = lane_mask;
            for (int i = 0; i < LANES; i++) begin
                base_d[i*ADDR_W +: ADDR_W] = lane_addr[i*ADDR_W +: ADDR_W] & keep_mask;
            end
        end else if (clear_en) begin
            pend_d = pend_q & ~hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            base_q <= '0;
        end else begin
            pend_q <= pend_d;
            base_q <= base_d;
        end
    end

    assign pend     = pend_q;
    assign base     = base_q;
    assign rest_any = |(pend_q & ~hit);

    AST_LOAD_CLEAR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !clear_en);                                              // R8
    AST_CLEAR_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_en && !load) |=> ((pend_q & ~$past(pend_q)) == '0));       // R3

endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
    parameter int LANES      = 32,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 128,
    parameter int SEG_BYTES  = 32
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     req_valid,
    output logic                                     req_ready,
    input  logic [LANES*ADDR_W-1:0]                  req_addr,
    input  logic [LANES-1:0]                         req_mask,
    input  logic                                     req_uncached,
    output logic                                     txn_valid,
    input  logic                                     txn_ready,
    output logic [ADDR_W-1:0]                        txn_base,
    output logic [$clog2(LINE_BYTES):0]              txn_size,
    output logic                                     done_pulse,
    output logic [$clog2(LANES+1)-1:0]               done_count,
    output logic [$clog2(LANES*LINE_BYTES+1)-1:0]    done_bytes
);
    import coal_pkg::*;

    localparam int SIZE_W  = $clog2(LINE_BYTES) + 1;
    localparam int CNT_W   = $clog2(LANES + 1);
    localparam int BYTES_W = $clog2(LANES * LINE_BYTES + 1);

    typedef struct packed {
        coal_state_e         state;
        logic                uncached;
        logic [CNT_W-1:0]    count;
        logic [BYTES_W-1:0]  bytes;
        logic [ADDR_W-1:0]   last_base;
        logic                have_last;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                    load;
    logic                    hs;
    logic [ADDR_W-1:0]       keep_mask;
    logic [LANES-1:0]        pend;
    logic [LANES*ADDR_W-1:0] lane_base;
    logic                    rest_any;
    logic                    any_pend;
    logic [ADDR_W-1:0]       min_base;

    assign req_ready = (ctl_q.state == ST_IDLE);
    assign load      = req_valid && req_ready;
    assign keep_mask = req_uncached ? ~ADDR_W'(SEG_BYTES - 1) : ~ADDR_W'(LINE_BYTES - 1);
    assign txn_valid = (ctl_q.state == ST_BUSY) && any_pend;
    assign hs        = txn_valid && txn_ready;
    assign txn_base  = min_base;
    assign txn_size  = ctl_q.uncached ? SIZE_W'(SEG_BYTES) : SIZE_W'(LINE_BYTES);

    coal_lane_bank #(.LANES(LANES), .ADDR_W(ADDR_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .lane_addr  (req_addr),
        .lane_mask  (req_mask),
        .keep_mask  (keep_mask),
        .clear_en   (hs),
        .clear_base (min_base),
        .pend       (pend),
        .base       (lane_base),
        .rest_any   (rest_any)
    );

    coal_min_tree #(.LANES(LANES), .ADDR_W(ADDR_W)) u_min (
        .vld      (pend),
        .base     (lane_base),
        .any      (any_pend),
        .min_base (min_base)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (load) begin
                    ctl_d.state     = ST_BUSY;
                    ctl_d.uncached  = req_uncached;
                    ctl_d.count     = '0;
                    ctl_d.bytes     = '0;
                    ctl_d.have_last = 1'b0;
                end
            end
            ST_BUSY: begin
                if (!any_pend) begin
                    ctl_d.state = ST_DONE;
                end else if (hs) begin
                    ctl_d.count     = ctl_q.count + CNT_W'(1);
                    ctl_d.bytes     = ctl_q.bytes + BYTES_W'(txn_size);
                    ctl_d.last_base = min_base;
                    ctl_d.have_last = 1'b1;
                    if (!rest_any) ctl_d.state = ST_DONE;
                end
            end
            ST_DONE: begin
                ctl_d.state = ST_IDLE;
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, uncached: 1'b0, count: '0, bytes: '0,
                       last_base: '0, have_last: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign done_pulse = (ctl_q.state == ST_DONE);
    assign done_count = ctl_q.count;
    assign done_bytes = ctl_q.bytes;

    AST_ALIGNED_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> ((txn_base & ADDR_W'(txn_size - 1)) == '0));         // R1
    AST_LEGAL_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_size == SIZE_W'(SEG_BYTES) || txn_size == SIZE_W'(LINE_BYTES))); // R2
    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && ctl_q.have_last) |-> (txn_base > ctl_q.last_base));  // R5
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_base) && $stable(txn_size))); // R6
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);                                       // R7
    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (done_count <= CNT_W'(LANES)));                     // R3
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid || done_pulse) |-> !req_ready);                         // R8

endmodule

// File: tb/warp_coalescer_tb.sv
module warp_coalescer_tb;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1023:0] req_addr = '0;
    logic [31:0]   req_mask = '0;
    logic          req_uncached = 1'b0;
    logic          txn_valid;
    logic          txn_ready = 1'b0;
    logic [31:0]   txn_base;
    logic [7:0]    txn_size;
    logic          done_pulse;
    logic [5:0]    done_count;
    logic [12:0]   done_bytes;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [31:0] a [32];
    logic [31:0] exp_list [32];
    int          exp_n;
    logic [31:0] got_list [40];
    int          got_n;

    always #5 clk = ~clk;

    warp_coalescer u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_mask(req_mask), .req_uncached(req_uncached),
        .txn_valid(txn_valid), .txn_ready(txn_ready), .txn_base(txn_base),
        .txn_size(txn_size), .done_pulse(done_pulse), .done_count(done_count),
        .done_bytes(done_bytes)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic void build_expected(input logic [31:0] m, input bit unc);
        logic [31:0] keep;
        logic [32:0] prev;
        keep = unc ? ~32'd31 : ~32'd127;
        exp_n = 0;
        prev = '1;
        forever begin
            logic [32:0] best;
            best = '1;
            for (int i = 0; i < 32; i++) begin
                logic [32:0] u;
                u = {1'b0, a[i] & keep};
                if (m[i] && (prev == '1 || u > prev) && (best == '1 || u < best)) best = u;
            end
            if (best == '1) break;
            exp_list[exp_n] = best[31:0];
            exp_n++;
            prev = best;
        end
    endfunction

    task automatic run_instr(input logic [31:0] m, input bit unc, input string tag);
        bit last_hs;
        bit stalled;
        logic [31:0] stall_base;
        int iters;
        bit list_ok;
        int unit;
        unit = unc ? 32 : 128;
        build_expected(m, unc);
        while (!req_ready) @(negedge clk);
        for (int i = 0; i < 32; i++) req_addr[i*32 +: 32] = a[i];
        req_mask = m;
        req_uncached = unc;
        req_valid = 1'b1;
        @(negedge clk);
        // keep a competing request offered while the block is busy (R8)
        for (int i = 0; i < 32; i++) req_addr[i*32 +: 32] = 32'h0F00_0000 + 32'(i * 512);
        req_mask = '1;
        if (m != 0) check(txn_valid === 1'b1, {"R10 first txn ", tag}, txn_valid, 1);
        got_n = 0; last_hs = 0; stalled = 0; stall_base = '0; iters = 0;
        while (!done_pulse && iters < 400) begin
            last_hs = 0;
            if (txn_valid) begin
                if (stalled) check(txn_base === stall_base, {"R6 hold ", tag}, txn_base, stall_base);
                check(txn_size == 8'(unit), {"R1 R2 size ", tag}, txn_size, unit);
                txn_ready = ($urandom % 4) != 0;
                if (txn_ready) begin
                    if (got_n < 40) got_list[got_n] = txn_base;
                    got_n++;
                    last_hs = 1;
                    stalled = 0;
                end else begin
                    stalled = 1;
                    stall_base = txn_base;
                end
            end else begin
                txn_ready = 1'b0;
            end
            @(negedge clk);
            iters++;
        end
        txn_ready = 1'b0;
        req_valid = 1'b0;
        check(done_pulse === 1'b1, {"R7 done seen ", tag}, done_pulse, 1);
        if (exp_n == 0) check(iters == 1, {"R10 R4 empty timing ", tag}, iters, 1);
        else            check(last_hs, {"R10 done after last ", tag}, last_hs, 1);
        list_ok = (got_n == exp_n);
        for (int i = 0; i < exp_n && i < got_n && i < 40; i++)
            if (got_list[i] !== exp_list[i]) list_ok = 0;
        check(list_ok, {"R3 R5 list ", tag}, got_n, exp_n);
        check(done_count == 6'(exp_n), {"R7 count ", tag}, done_count, exp_n);
        check(done_bytes == 13'(exp_n * unit), {"R7 bytes ", tag}, done_bytes, exp_n * unit);
        check(req_ready === 1'b0, {"R8 busy at done ", tag}, req_ready, 0);
        @(negedge clk);
        check(done_pulse === 1'b0 && req_ready === 1'b1, {"R7 R8 after done ", tag},
              {done_pulse, req_ready}, 2'b01);
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h1357_2468));
        repeat (3) @(negedge clk);
        check(req_ready === 1'b1 && txn_valid === 1'b0 && done_pulse === 1'b0,
              "R8 reset state", {req_ready, txn_valid, done_pulse}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);

        for (int u = 0; u < 2; u++) begin
            // R3 aligned consecutive
            for (int i = 0; i < 32; i++) a[i] = 32'h0000_2000 + 32'(4 * i);
            run_instr('1, u[0], "aligned");
            // R3 permuted
            for (int i = 0; i < 32; i++) a[i] = 32'h0000_2000 + 32'(4 * ((i * 7) % 32));
            run_instr('1, u[0], "permuted");
            // R3 misaligned
            for (int i = 0; i < 32; i++) a[i] = 32'h0000_2004 + 32'(4 * i);
            run_instr('1, u[0], "misaligned");
            // R3 same word
            for (int i = 0; i < 32; i++) a[i] = 32'h0001_0040;
            run_instr('1, u[0], "same word");
            // R4 empty mask
            run_instr('0, u[0], "empty");
            // R9 low bits
            for (int i = 0; i < 32; i++) a[i] = 32'h0000_3000 + 32'(4 * i) + 32'(i % 4);
            run_instr('1, u[0], "low bits");
            // R4 inactive lanes far away
            for (int i = 0; i < 32; i++) a[i] = (i % 2 == 0) ? 32'h0000_4000 : 32'hFFFF_FF80;
            run_instr(32'h5555_5555, u[0], "inactive");
        end

        for (int k = 0; k < 60; k++) begin
            logic [31:0] region;
            region = $urandom & 32'hFFFF_F000;
            for (int i = 0; i < 32; i++) begin
                if (k % 3 == 0) a[i] = $urandom;
                else a[i] = region + ($urandom % (32'd256 << (k % 4)));
            end
            run_instr((k % 5 == 0) ? 32'($urandom) : '1, bit'($urandom % 2), "random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule